// File: doc/BRIEF.md
# I2C Master Wait and Stop Controller

This block sits beside an I2C byte engine and owns two things: clock stretching and the end-of-transfer stop condition. At the end of a byte the engine signals that the 8th or the 9th SCL clock has completed. If the wait-point select matches that clock, the controller pulls SCL low and holds it low until software lets the transfer continue. Software continues either with a wait-release strobe or, while transmitting, by loading the next byte into the shift register.

A stop request from software is accepted only in a legal window. The block must be the bus master and must be parked in a wait. In transmit the wait must follow the 9th clock, so that the acknowledge clock is never disturbed. In receive the acknowledge enable must be off, meaning the last byte was not acknowledged. A stop requested in an 8th-clock wait during reception runs its sequence where the 9th clock would have been, so the stop lands in the high phase of that clock. An accepted stop is generated in three steps:

1. Pull SDA low while SCL is still held.
2. Release SCL and wait for the line to read high.
3. Release SDA.

An on-chip detector watches the bus for SDA rising while SCL is high. It clears the pending request. An arbitration loss, a communication exit or disabling the module also clears it.

Top module: `i2c_wait_stop_ctrl`

## Requirements
- R1: With `wait_sel9`=0, a `byte_end8` pulse puts the block into a wait. With `wait_sel9`=1, a `byte_end9` pulse does so. Two cycles later `scl_low_o` is 1. An end pulse that does not match the select causes no wait.
- R2: A `wait_rel` pulse ends any wait. A `shreg_wr` pulse ends a wait only when `tx_mode`=1. In receive, a `shreg_wr` pulse leaves SCL held.
- R3: A `wait_rel` that ends a 9th-clock wait with `tx_mode`=1 makes `tx_clr_o` high for exactly one cycle, in the cycle after the strobe. Any other release leaves `tx_clr_o` at 0.
- R4: `stop_wr` is accepted (`stop_busy_o` goes to 1 one cycle later) only when all of these hold:
  - `is_master`=1
  - the block is in a wait
  - in transmit, that wait follows the 9th clock; in receive, `ack_en`=0

  Outside these conditions the write is ignored. This includes writes made while a byte is still moving.
- R5: If `stop_wr` and `strt_req` arrive in the same cycle, no stop is accepted and `req_clash_o` becomes 1. It stays at 1 until the module is disabled.
- R6: An accepted stop pulls SDA low while SCL is still held, for exactly QTR_CYC cycles. It then releases SCL and keeps SDA low for QTR_CYC to QTR_CYC+2 further cycles, and releases SDA only while SCL reads high.
- R7: A second `stop_wr` while a stop is pending is ignored. The SDA-low/SCL-low phase keeps its length of QTR_CYC cycles.
- R8: `stop_det_o` pulses high for one cycle when SDA rises while SCL is high. `stop_busy_o` is 0 in the cycle after that pulse.
- R9: `arb_lost` or `comm_exit` clears a pending stop in the next cycle. `scl_low_o` and `sda_low_o` are both 0 two cycles after the strobe.
- R10: While `mod_en`=0, after one clock edge:
  - `scl_low_o` and `sda_low_o` are 0
  - `stop_busy_o` and `req_clash_o` are 0
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Module enable |
| stop_wr | input | 1 | Software writes a 1 to the stop request |
| strt_req | input | 1 | Software writes a 1 to the start request |
| ack_en | input | 1 | Acknowledge enable |
| wait_sel9 | input | 1 | Wait point: 0 = after 8th clock, 1 = after 9th clock |
| wait_rel | input | 1 | Wait-release strobe |
| comm_exit | input | 1 | Leave communication strobe |
| shreg_wr | input | 1 | Shift-register write strobe |
| is_master | input | 1 | Block is bus master |
| tx_mode | input | 1 | Transmit status |
| arb_lost | input | 1 | Arbitration lost pulse |
| byte_end8 | input | 1 | 8th SCL clock finished |
| byte_end9 | input | 1 | 9th SCL clock finished |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_low_o | output | 1 | Pull SCL low (open-drain enable) |
| sda_low_o | output | 1 | Pull SDA low (open-drain enable) |
| stop_det_o | output | 1 | One-cycle stop-condition detect |
| stop_busy_o | output | 1 | Stop request pending |
| req_clash_o | output | 1 | Stop and start requested together |
| tx_clr_o | output | 1 | Ask engine to drop transmit status and float SDA |

## Verification
The bench tests the acceptance window against the full mix of master/slave, transmit/receive, acknowledge enable and wait point. A design that checks only the master flag would start a stop in the middle of an acknowledge clock. A design that ignores `ack_en` in receive would accept a stop after an acknowledged byte.

The bench times the SDA-low and SCL-released phases of every stop. It also repeats the write mid-sequence: a design that restarts its counter on the second write stretches the first phase.

Simultaneous start and stop, a shift-register write during a receive wait, and abort strobes in the middle of a stop are each driven. A wrong design would start a stop anyway, let SCL go early, or keep a lingering pull on a line.

// File: rtl/i2c_ws_pkg.sv
package i2c_ws_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_STOP1 = 3'd2,
    ST_STOP2 = 3'd3,
    ST_STOP3 = 3'd4
  } ws_state_e;
endpackage

// File: rtl/i2c_ws_fsm.sv
module i2c_ws_fsm
  import i2c_ws_pkg::*;
#(
  parameter int QTR_CYC = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      mod_en,
  input  logic      stop_wr,
  input  logic      strt_req,
  input  logic      ack_en,
  input  logic      wait_sel9,
  input  logic      wait_rel,
  input  logic      comm_exit,
  input  logic      shreg_wr,
  input  logic      is_master,
  input  logic      tx_mode,
  input  logic      arb_lost,
  input  logic      byte_end8,
  input  logic      byte_end9,
  input  logic      scl_in,
  input  logic      stop_det,
  output ws_state_e st_q,
  output logic      pend_q,
  output logic      err_q,
  output logic      txclr_q
);
  localparam int CW = $clog2(QTR_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          pt9_q;
  logic          abort;
  logic          accept;
  logic          clash;

  assign abort  = arb_lost | comm_exit;
  assign clash  = stop_wr & strt_req;
  assign accept = stop_wr & ~strt_req & is_master & ~pend_q &
                  (tx_mode ? pt9_q : ~ack_en);

  always_ff @(posedge clk) begin
    if (rst || !mod_en) begin
      st_q    <= ST_RUN;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      pt9_q   <= 1'b0;
      txclr_q <= 1'b0;
    end else begin
      txclr_q <= 1'b0;
      if (clash) err_q <= 1'b1;
      if (stop_det || abort) pend_q <= 1'b0;
      case (st_q)
        ST_RUN: begin
          if (byte_end8 && !wait_sel9) begin
            st_q  <= ST_WAIT;
            pt9_q <= 1'b0;
          end else if (byte_end9 && wait_sel9) begin
            st_q  <= ST_WAIT;
            pt9_q <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (abort) begin
            st_q <= ST_RUN;
          end else if (accept) begin
            pend_q <= 1'b1;
            st_q   <= ST_STOP1;
            cnt_q  <= '0;
          end else if (wait_rel) begin
            st_q    <= ST_RUN;
            txclr_q <= tx_mode & pt9_q;
          end else if (shreg_wr && tx_mode) begin
            st_q <= ST_RUN;
          end
        end
        ST_STOP1: begin
          if (abort) st_q <= ST_RUN;
          else if (cnt_q == CNT_LAST) begin
            st_q  <= ST_STOP2;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_STOP2: begin
          if (abort) st_q <= ST_RUN;
          else if (scl_in) begin
            if (cnt_q == CNT_LAST) begin
              st_q  <= ST_STOP3;
              cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP3: begin
          if (abort || stop_det) st_q <= ST_RUN;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  // R5
  clash_blocks_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (clash && mod_en) |=> (!$rose(pend_q) && err_q));

  // R4
  stop_needs_master_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(is_master));

  // R9
  abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> !pend_q);

  // R10
  disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> (!pend_q && !err_q));

  // R3
  txclr_single_chk: assert property (@(posedge clk) disable iff (rst)
    txclr_q |=> !txclr_q);
endmodule

// File: rtl/i2c_ws_line_drv.sv
module i2c_ws_line_drv
  import i2c_ws_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mod_en,
  input  ws_state_e st,
  output logic      scl_low_o,
  output logic      sda_low_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
    end else begin
      scl_low_o <= mod_en & ((st == ST_WAIT) | (st == ST_STOP1));
      sda_low_o <= mod_en & ((st == ST_STOP1) | (st == ST_STOP2));
    end
  end

  // R10
  off_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> (!scl_low_o && !sda_low_o));
endmodule

// File: rtl/i2c_ws_stop_det.sv
module i2c_ws_stop_det (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic det_o
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b0;
      sda_q <= 1'b0;
      det_o <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      det_o <= sda_in & ~sda_q & scl_in & scl_q;
    end
  end

  // R8
  det_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    det_o |=> !det_o);
endmodule

// File: rtl/i2c_wait_stop_ctrl.sv
module i2c_wait_stop_ctrl
  import i2c_ws_pkg::*;
#(
  parameter int QTR_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic mod_en,
  input  logic stop_wr,
  input  logic strt_req,
  input  logic ack_en,
  input  logic wait_sel9,
  input  logic wait_rel,
  input  logic comm_exit,
  input  logic shreg_wr,
  input  logic is_master,
  input  logic tx_mode,
  input  logic arb_lost,
  input  logic byte_end8,
  input  logic byte_end9,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_low_o,
  output logic sda_low_o,
  output logic stop_det_o,
  output logic stop_busy_o,
  output logic req_clash_o,
  output logic tx_clr_o
);
  ws_state_e st_q;
  logic      det;

  i2c_ws_fsm #(.QTR_CYC(QTR_CYC)) fsm_i (
    .clk(clk), .rst(rst), .mod_en(mod_en), .stop_wr(stop_wr),
    .strt_req(strt_req), .ack_en(ack_en), .wait_sel9(wait_sel9),
    .wait_rel(wait_rel), .comm_exit(comm_exit), .shreg_wr(shreg_wr),
    .is_master(is_master), .tx_mode(tx_mode), .arb_lost(arb_lost),
    .byte_end8(byte_end8), .byte_end9(byte_end9), .scl_in(scl_in),
    .stop_det(det), .st_q(st_q), .pend_q(stop_busy_o),
    .err_q(req_clash_o), .txclr_q(tx_clr_o)
  );

  i2c_ws_line_drv drv_i (
    .clk(clk), .rst(rst), .mod_en(mod_en), .st(st_q),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o)
  );

  i2c_ws_stop_det det_i (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .det_o(det)
  );

  assign stop_det_o = det;

  // R6
  sda_after_scl_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_low_o) && $past(st_q) == ST_STOP3) |-> scl_in);

  // R8
  det_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
    det |=> !stop_busy_o);
endmodule

// File: tb/i2c_wait_stop_ctrl_tb.sv
module i2c_wait_stop_ctrl_tb_top;
  localparam int QTR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod_en = 1'b0, stop_wr = 1'b0, strt_req = 1'b0, ack_en = 1'b0;
  logic wait_sel9 = 1'b0, wait_rel = 1'b0, comm_exit = 1'b0, shreg_wr = 1'b0;
  logic is_master = 1'b0, tx_mode = 1'b0, arb_lost = 1'b0;
  logic byte_end8 = 1'b0, byte_end9 = 1'b0;
  logic scl_low_o, sda_low_o, stop_det_o, stop_busy_o, req_clash_o, tx_clr_o;
  logic scl_in, sda_in;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  assign scl_in = ~scl_low_o;
  assign sda_in = ~sda_low_o;

  always #2.5 clk = ~clk;

  i2c_wait_stop_ctrl #(.QTR_CYC(QTR)) dut_i (
    .clk(clk), .rst(rst), .mod_en(mod_en), .stop_wr(stop_wr),
    .strt_req(strt_req), .ack_en(ack_en), .wait_sel9(wait_sel9),
    .wait_rel(wait_rel), .comm_exit(comm_exit), .shreg_wr(shreg_wr),
    .is_master(is_master), .tx_mode(tx_mode), .arb_lost(arb_lost),
    .byte_end8(byte_end8), .byte_end9(byte_end9), .scl_in(scl_in),
    .sda_in(sda_in), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
    .stop_det_o(stop_det_o), .stop_busy_o(stop_busy_o),
    .req_clash_o(req_clash_o), .tx_clr_o(tx_clr_o)
  );

  function automatic bit exp_accept(bit m, bit tx, bit ack, bit pt9, bit clash);
    return m && !clash && (tx ? pt9 : !ack);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic enter_wait(bit sel9);
    wait_sel9 = sel9;
    if (sel9) byte_end9 = 1'b1; else byte_end8 = 1'b1;
    tick();
    byte_end8 = 1'b0; byte_end9 = 1'b0;
    tick();
    chk("R1 wait holds SCL", scl_low_o, 1);
  endtask

  task automatic pulse_stop(bit with_start);
    stop_wr = 1'b1; strt_req = with_start;
    tick();
    stop_wr = 1'b0; strt_req = 1'b0;
  endtask

  task automatic drain();
    wait_rel = 1'b1; tick(); wait_rel = 1'b0;
    repeat (3) tick();
  endtask

  // Watches an accepted stop from the cycle after the write.
  task automatic watch_stop(bit rewrite);
    int a = 0, b = 0, seen = 0;
    for (int i = 0; i < 200 && seen == 0; i++) begin
      if (sda_low_o && scl_low_o) a++;
      if (sda_low_o && !scl_low_o) b++;
      if (stop_det_o) seen = 1;
      if (rewrite && i == 1) stop_wr = 1'b1;
      tick();
      stop_wr = 1'b0;
    end
    chk(rewrite ? "R7 SDA-low/SCL-low length after rewrite" : "R6 SDA-low/SCL-low length", a, QTR);
    chk("R6 SDA held after SCL release lower bound", int'(b >= QTR), 1);
    chk("R6 SDA held after SCL release upper bound", int'(b <= QTR + 2), 1);
    chk("R8 stop detected", seen, 1);
    chk("R8 busy cleared after detect", stop_busy_o, 0);
    chk("R8 detect is one cycle", stop_det_o, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R11 reset state
    chk("R11 scl_low", scl_low_o, 0);
    chk("R11 sda_low", sda_low_o, 0);
    chk("R11 busy", stop_busy_o, 0);
    chk("R11 clash", req_clash_o, 0);
    chk("R11 det", stop_det_o, 0);
    chk("R11 txclr", tx_clr_o, 0);
    mod_en = 1'b1; is_master = 1'b1;
    tick();

    // R1 mismatched end pulse does not wait
    wait_sel9 = 1'b1; byte_end8 = 1'b1; tick(); byte_end8 = 1'b0; tick();
    chk("R1 no wait on mismatched clock", scl_low_o, 0);

    // R4 stop during a moving byte ignored
    ack_en = 1'b0; tx_mode = 1'b0;
    pulse_stop(1'b0);
    chk("R4 stop outside wait ignored", stop_busy_o, 0);
    tick();
    chk("R4 stop outside wait no SDA pull", sda_low_o, 0);

    // R4 slave write ignored
    is_master = 1'b0;
    enter_wait(1'b1);
    pulse_stop(1'b0);
    chk("R4 slave stop ignored", stop_busy_o, 0);
    drain();
    is_master = 1'b1;

    // R4 transmit at 8th-clock wait rejected
    tx_mode = 1'b1;
    enter_wait(1'b0);
    pulse_stop(1'b0);
    chk("R4 tx 8th wait rejected", stop_busy_o, 0);
    drain();

    // R4/R6 receive, 8th-clock wait, ack off: accepted
    tx_mode = 1'b0; ack_en = 1'b0;
    enter_wait(1'b0);
    pulse_stop(1'b0);
    chk("R4 rx 8th wait accepted", stop_busy_o, 1);
    watch_stop(1'b0);
    repeat (2) tick();

    // R9 arbitration loss during stop
    enter_wait(1'b1);
    pulse_stop(1'b0);
    chk("R4 accepted before abort", stop_busy_o, 1);
    arb_lost = 1'b1; tick(); arb_lost = 1'b0;
    chk("R9 arb loss clears busy", stop_busy_o, 0);
    tick();
    chk("R9 arb loss SCL freed", scl_low_o, 0);
    chk("R9 arb loss SDA freed", sda_low_o, 0);
    repeat (2) tick();

    // R9 communication exit during stop
    enter_wait(1'b1);
    pulse_stop(1'b0);
    tick();
    comm_exit = 1'b1; tick(); comm_exit = 1'b0;
    chk("R9 exit clears busy", stop_busy_o, 0);
    tick();
    chk("R9 exit SCL freed", scl_low_o, 0);
    chk("R9 exit SDA freed", sda_low_o, 0);
    repeat (2) tick();

    // R10 disable inside a wait
    enter_wait(1'b1);
    mod_en = 1'b0; tick();
    chk("R10 disable frees SCL", scl_low_o, 0);
    chk("R10 disable busy", stop_busy_o, 0);
    mod_en = 1'b1; repeat (2) tick();

    // Random mix
    for (int it = 0; it < 60; it++) begin
      bit m, tx, ack, sel9, clash, rew, acc, use_rel;
      m = ($urandom % 4) != 0; tx = $urandom % 2; ack = $urandom % 2;
      sel9 = $urandom % 2; clash = ($urandom % 6) == 0; rew = ($urandom % 3) == 0;
      is_master = m; tx_mode = tx; ack_en = ack;
      enter_wait(sel9);
      acc = exp_accept(m, tx, ack, sel9, clash);
      pulse_stop(clash);
      chk("R4 acceptance window", stop_busy_o, acc);
      if (clash) begin
        chk("R5 clash flag", req_clash_o, 1);
        drain();
        mod_en = 1'b0; tick();
        chk("R10 disable clears clash", req_clash_o, 0);
        mod_en = 1'b1; tick();
      end else if (acc) begin
        watch_stop(rew);
        repeat (2) tick();
      end else begin
        if (!tx) begin
          shreg_wr = 1'b1; tick(); shreg_wr = 1'b0; tick();
          chk("R2 shift write ignored in receive", scl_low_o, 1);
          use_rel = 1'b1;
        end else use_rel = $urandom % 2;
        if (use_rel) wait_rel = 1'b1; else shreg_wr = 1'b1;
        tick();
        wait_rel = 1'b0; shreg_wr = 1'b0;
        chk("R3 transmit-status clear", tx_clr_o, int'(use_rel && tx && sel9));
        tick();
        chk("R2 release frees SCL", scl_low_o, 0);
        chk("R3 clear lasts one cycle", tx_clr_o, 0);
        tick();
      end
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule